// File: doc/BRIEF.md
# Wire-to-message interrupt bridge

This block gathers wired interrupt lines from peripherals that have no message-signalled interrupt support of their own. For each asserted line it emits one message that a downstream translation service can write to a fixed MSI doorbell. Input lines are grouped into nodes of up to 128 pins, and a parameter sets the number of nodes. Every pin has its own trigger type (rising edge or active-high level), a latched status bit, and a vector register that holds the event and device identifiers carried by its message.

Software programs the block through a simple word-addressed register port. Through this port it sets each pin's vector and trigger type, and it acknowledges an interrupt by writing a one to the pin's bit in a chip-wide clear bank. Pending pins are served one at a time in fixed priority order. Each message leaves on a valid/ready port and carries the event ID as its data. The doorbell address is fixed in hardware, so it does not appear on the port. Masking, routing and affinity are the parent controller's concern.

Global pin numbers start at 64, because numbers below that are reserved. Input bit `irq_in[i]` belongs to global pin `p = i + 64`. Its node is `n = i/128 + 1` (nodes are numbered from 1) and its local index is `l = i % 128`.

Top module: `irq_msg_bridge`

## Requirements
- R1: Pin `i` (global `p = i+64`) belongs to node `n = i/128+1` with local index `l = i%128`. Node `n` owns the byte window starting at `n*0x1000`, and the pin's vector register is at `n*0x1000 + 0x200 + 4*l`. With two nodes the last pin (global 319) has its vector at 0x23FC, its type bit at bit 31 of 0x200C and its clear bit at bit 31 of 0xA01C.
- R2: A vector register holds the event ID in bits [21:12] and the device ID in bits [11:0]. It reads back the value last written, with bits [31:22] as zero, and it resets to zero.
- R3: The trigger-type word for local pins `32k..32k+31` of node `n` is at `n*0x1000 + 4*k`, with the pin at bit `l%32`. A 1 selects active-high level and a 0 selects rising edge. The word reads back the value last written and resets to zero (all pins edge).
- R4: In edge mode a rising edge of the line sets the status. The pin then sends exactly one message and sends no more, even while the line stays high, until it is cleared. A clear written while the line is still high produces no new message, and a later rising edge produces exactly one.
- R5: In level mode a high line sets the status, and the pin sends one message. If the line is still high when the clear is written, the status sets again and one new message follows. If the line is low at the clear, no message follows.
- R6: The clear bank starts at 0xA000. The word at `0xA000 + 4*(i/32)` has pin `i` at bit `i%32`. Writing 1 clears that pin's status, writing 0 has no effect, and the bank always reads zero.
- R7: A message carries the event ID (`msg_event`) and device ID (`msg_dev`) from the pin's vector register. Once `msg_valid` is high, it and both fields hold steady until a cycle in which `msg_ready` is also high.
- R8: Among pending pins the lowest index `i` is served first, and only one message is outstanding at a time. In the cycle after a handshake `msg_valid` is low.
- R9: Addresses outside the defined registers read zero and ignore writes. This includes the window of node 0, the windows above the last node, and addresses that are not word-aligned.
- R10: After reset `msg_valid` is low. When no message is outstanding, a line change sampled at clock edge k raises `msg_valid` after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_NODES*PINS_PER_NODE | Wired interrupt lines; bit i is global pin i+64 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_event | output | 10 | Event ID of the message (its data) |
| msg_dev | output | 12 | Device ID of the message |

## Verification
A status or sent bit stuck in the wrong state shows up at the message port within a few cycles. It appears either as a missing message two edges after a line change, or as a second message for a pin that has not been cleared. The bench looks for both after every stimulus with a quiet window. A wrong address decode sends a pin's trigger type, vector or clear to a different pin. That appears as the wrong event or device ID on the next message, or as a level pin that is not re-armed by its clear. Random rounds place several pins in each node and clear word at once, so the order in which messages leave also exposes a priority or index fault at the first conflict.

// File: rtl/imb_pkg.sv
`timescale 1ns/1ps
package imb_pkg;
    localparam int ADDR_W        = 16;
    localparam int DATA_W        = 32;
    localparam int EVT_W         = 10;
    localparam int DEV_W         = 12;
    localparam int VEC_W         = EVT_W + DEV_W;
    localparam int WIN_BYTES     = 'h1000;
    localparam int VEC_OFS       = 'h200;
    localparam int CLR_BANK      = 'hA000;
    localparam int BITS_PER_WORD = 32;

    // Register word layout: event ID above device ID, packed from bit 0.
    typedef struct packed {
        logic [EVT_W-1:0] evt;
        logic [DEV_W-1:0] dev;
    } vec_t;

    typedef enum logic [1:0] {HIT_NONE, HIT_VEC, HIT_TYPE, HIT_CLR} hit_e;

    // idx: pin index for vectors, first pin of the word for type and clear.
    typedef struct packed {
        hit_e        kind;
        logic [15:0] idx;
    } dec_t;

    function automatic dec_t decode_addr(logic [ADDR_W-1:0] a, int nodes, int ppn);
        dec_t d;
        int   ai;
        int   node;
        int   off;
        ai     = int'(a);
        node   = ai / WIN_BYTES;
        off    = ai % WIN_BYTES;
        d.kind = HIT_NONE;
        d.idx  = '0;
        if (a[1:0] == 2'b00) begin
            if (ai >= CLR_BANK && ai < CLR_BANK + (nodes * ppn / BITS_PER_WORD) * 4) begin
                d.kind = HIT_CLR;
                d.idx  = 16'((ai - CLR_BANK) / 4 * BITS_PER_WORD);
            end else if (node >= 1 && node <= nodes) begin
                if (off >= VEC_OFS && off < VEC_OFS + ppn * 4) begin
                    d.kind = HIT_VEC;
                    d.idx  = 16'((node - 1) * ppn + (off - VEC_OFS) / 4);
                end else if (off < (ppn / BITS_PER_WORD) * 4) begin
                    d.kind = HIT_TYPE;
                    d.idx  = 16'((node - 1) * ppn + off / 4 * BITS_PER_WORD);
                end
            end
        end
        return d;
    endfunction
endpackage

// File: rtl/imb_regfile.sv
`timescale 1ns/1ps
module imb_regfile
    import imb_pkg::*;
#(
    parameter int NUM_NODES     = 2,
    parameter int PINS_PER_NODE = 128,
    localparam int NPINS        = NUM_NODES * PINS_PER_NODE,
    localparam int PIN_W        = $clog2(NPINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NPINS-1:0]  level_mode,
    output logic [NPINS-1:0]  clr_pulse,
    input  logic [PIN_W-1:0]  sel_idx,
    output vec_t              sel_vec
);
    vec_t             vec_q [NPINS];
    logic [NPINS-1:0] lvl_q;
    dec_t             dec;
    logic [PIN_W-1:0] pin_idx;

    always_comb begin
        dec     = decode_addr(reg_addr, NUM_NODES, PINS_PER_NODE);
        pin_idx = PIN_W'(dec.idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPINS; i++) vec_q[i] <= '0;
            lvl_q <= '0;
        end else if (reg_wr) begin
            if (dec.kind == HIT_VEC)  vec_q[pin_idx] <= vec_t'(reg_wdata[VEC_W-1:0]);
            if (dec.kind == HIT_TYPE) lvl_q[pin_idx +: BITS_PER_WORD] <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (dec.kind)
            HIT_VEC:  reg_rdata = DATA_W'(vec_q[pin_idx]);
            HIT_TYPE: reg_rdata = lvl_q[pin_idx +: BITS_PER_WORD];
            default:  reg_rdata = '0;   // clear bank and holes read zero
        endcase
    end

    always_comb begin
        clr_pulse = '0;
        if (reg_wr && dec.kind == HIT_CLR) clr_pulse[pin_idx +: BITS_PER_WORD] = reg_wdata;
    end

    assign level_mode = lvl_q;
    assign sel_vec    = vec_q[sel_idx];
endmodule

// File: rtl/imb_pin_status.sv
`timescale 1ns/1ps
module imb_pin_status #(
    parameter int NPINS = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] irq_in,
    input  logic [NPINS-1:0] level_mode,
    input  logic [NPINS-1:0] clr_pulse,
    input  logic [NPINS-1:0] done,
    output logic [NPINS-1:0] pending
);
    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic line_q, stat_q, sent_q, set_c;

        assign set_c = level_mode[g] ? irq_in[g] : (irq_in[g] & ~line_q);

        always_ff @(posedge clk) begin
            if (rst) begin
                line_q <= 1'b0;
                stat_q <= 1'b0;
                sent_q <= 1'b0;
            end else begin
                line_q <= irq_in[g];
                if (clr_pulse[g]) begin
                    stat_q <= set_c;    // a still-high level line re-arms at once
                    sent_q <= 1'b0;
                end else begin
                    stat_q <= stat_q | set_c;
                    sent_q <= (sent_q | done[g]) & stat_q;
                end
            end
        end

        assign pending[g] = stat_q & ~sent_q;
    end
endmodule

// File: rtl/imb_msg_arb.sv
`timescale 1ns/1ps
module imb_msg_arb
    import imb_pkg::*;
#(
    parameter int NPINS  = 256,
    localparam int PIN_W = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pending,
    output logic [PIN_W-1:0] sel_idx,
    input  vec_t             sel_vec,
    output logic             msg_valid,
    input  logic             msg_ready,
    output vec_t             msg,
    output logic [NPINS-1:0] done
);
    logic             valid_q;
    logic [PIN_W-1:0] idx_q;
    vec_t             msg_q;

    always_comb begin
        sel_idx = '0;
        for (int i = NPINS - 1; i >= 0; i--) begin
            if (pending[i]) sel_idx = PIN_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            idx_q   <= '0;
            msg_q   <= '0;
        end else if (!valid_q) begin
            if (|pending) begin
                valid_q <= 1'b1;
                idx_q   <= sel_idx;
                msg_q   <= sel_vec;
            end
        end else if (msg_ready) begin
            valid_q <= 1'b0;
        end
    end

    always_comb begin
        done = '0;
        if (valid_q && msg_ready) done[idx_q] = 1'b1;
    end

    assign msg_valid = valid_q;
    assign msg       = msg_q;
endmodule

// File: rtl/irq_msg_bridge.sv
`timescale 1ns/1ps
module irq_msg_bridge
    import imb_pkg::*;
#(
    parameter int NUM_NODES     = 2,
    parameter int PINS_PER_NODE = 128,
    localparam int NPINS        = NUM_NODES * PINS_PER_NODE,
    localparam int PIN_W        = $clog2(NPINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  irq_in,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [EVT_W-1:0]  msg_event,
    output logic [DEV_W-1:0]  msg_dev
);
    logic [NPINS-1:0] level_mode, clr_pulse, done, pending;
    logic [PIN_W-1:0] sel_idx;
    vec_t             sel_vec, msg;

    imb_regfile #(.NUM_NODES(NUM_NODES), .PINS_PER_NODE(PINS_PER_NODE)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .level_mode(level_mode),
        .clr_pulse(clr_pulse), .sel_idx(sel_idx), .sel_vec(sel_vec)
    );

    imb_pin_status #(.NPINS(NPINS)) u_stat (
        .clk(clk), .rst(rst), .irq_in(irq_in), .level_mode(level_mode),
        .clr_pulse(clr_pulse), .done(done), .pending(pending)
    );

    imb_msg_arb #(.NPINS(NPINS)) u_arb (
        .clk(clk), .rst(rst), .pending(pending), .sel_idx(sel_idx),
        .sel_vec(sel_vec), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg(msg), .done(done)
    );

    assign msg_event = msg.evt;
    assign msg_dev   = msg.dev;
endmodule

// File: rtl/imb_bridge_chk.sv
`timescale 1ns/1ps
module imb_bridge_chk
    import imb_pkg::*;
#(
    parameter int NUM_NODES     = 2,
    parameter int PINS_PER_NODE = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [EVT_W-1:0]  msg_event,
    input logic [DEV_W-1:0]  msg_dev
);
    dec_t d;
    always_comb d = decode_addr(reg_addr, NUM_NODES, PINS_PER_NODE);

    // R7
    msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_event) && $stable(msg_dev));

    // R8
    msg_gap_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_ready |=> !msg_valid);

    // R6
    clr_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        d.kind == HIT_CLR |-> reg_rdata == '0);

    // R9
    hole_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        d.kind == HIT_NONE |-> reg_rdata == '0);

    // R2
    vec_readback_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr && d.kind == HIT_VEC |=>
            ($stable(reg_addr) |-> reg_rdata == DATA_W'($past(reg_wdata[VEC_W-1:0]))));

    // R10
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !msg_valid);
endmodule

bind irq_msg_bridge imb_bridge_chk #(.NUM_NODES(NUM_NODES), .PINS_PER_NODE(PINS_PER_NODE)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_event(msg_event), .msg_dev(msg_dev)
);

// File: tb/irq_msg_bridge_test.sv
`timescale 1ns/1ps
module irq_msg_bridge_test;
    localparam int NUM_NODES = 2;
    localparam int PPN       = 128;
    localparam int NPINS     = NUM_NODES * PPN;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [NPINS-1:0] irq = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msg_ready = 1'b0;
    logic        msg_valid;
    logic [9:0]  msg_event;
    logic [11:0] msg_dev;

    int checks = 0;
    int fails  = 0;
    logic [21:0] mvec [NPINS];

    irq_msg_bridge #(.NUM_NODES(NUM_NODES), .PINS_PER_NODE(PPN)) uut (
        .clk(clk), .rst(rst), .irq_in(irq), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_event(msg_event), .msg_dev(msg_dev)
    );

    // Address helpers from the requirement text (index i = global pin - 64).
    function automatic logic [15:0] vaddr(int i);
        return 16'((i / PPN + 1) * 'h1000 + 'h200 + (i % PPN) * 4);
    endfunction
    function automatic logic [15:0] taddr(int i);
        return 16'((i / PPN + 1) * 'h1000 + ((i % PPN) / 32) * 4);
    endfunction
    function automatic logic [15:0] caddr(int i);
        return 16'('hA000 + (i / 32) * 4);
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic set_vec(int i, logic [21:0] v);
        wr(vaddr(i), 32'(v));
        mvec[i] = v;
    endtask

    task automatic set_mode(int i, bit lvl);
        logic [31:0] w;
        rd(taddr(i), w);
        w[i % 32] = lvl;
        wr(taddr(i), w);
    endtask

    task automatic clear_pin(int i);
        wr(caddr(i), 32'(1) << (i % 32));
    endtask

    // Waits for a message, checks its fields and stability, then accepts it.
    task automatic take_msg(string req, int i);
        logic [21:0] cur;
        int hold;
        for (int t = 0; t < 40 && !msg_valid; t++) @(negedge clk);
        if (!msg_valid) begin
            check(1'b0, req, 32'd0, 32'd1);
        end else begin
            cur = {msg_event, msg_dev};
            check(cur == mvec[i], req, 32'(cur), 32'(mvec[i]));
            hold = int'($urandom % 3);
            for (int h = 0; h < hold; h++) begin
                @(negedge clk);
                check(msg_valid && {msg_event, msg_dev} == cur, "R7 hold",
                      32'({msg_event, msg_dev}), 32'(cur));
            end
            msg_ready = 1'b1;
            @(negedge clk);
            msg_ready = 1'b0;
            check(!msg_valid, "R8 gap after handshake", 32'(msg_valid), 32'd0);
        end
    endtask

    task automatic expect_quiet(string req, int n);
        bit seen = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        check(!seen, req, 32'(seen), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NPINS; i++) mvec[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 / R2 / R3 reset state
        check(!msg_valid, "R10 reset idle", 32'(msg_valid), 32'd0);
        rd(vaddr(0), v);   check(v == 0, "R2 vector reset", v, 32'd0);
        rd(16'h1000, v);   check(v == 0, "R3 type reset", v, 32'd0);

        // R2 readback masks to 22 bits
        wr(vaddr(36), 32'hFFFF_FFFF);
        rd(vaddr(36), v);  check(v == 32'h003F_FFFF, "R2 readback", v, 32'h003F_FFFF);
        set_vec(36, 22'h0);
        // R3 readback
        wr(16'h1004, 32'hA5A5_A5A5);
        rd(16'h1004, v);   check(v == 32'hA5A5_A5A5, "R3 readback", v, 32'hA5A5_A5A5);
        wr(16'h1004, 32'h0);
        // R6 clear bank reads zero
        wr(16'hA004, 32'hFFFF_FFFF);
        rd(16'hA004, v);   check(v == 0, "R6 clear reads zero", v, 32'd0);
        // R9 holes
        wr(16'h0200, 32'h0012_3456);
        rd(16'h0200, v);   check(v == 0, "R9 node0 window", v, 32'd0);
        wr(16'h3200, 32'h0012_3456);
        rd(16'h3200, v);   check(v == 0, "R9 absent node", v, 32'd0);
        rd(vaddr(0), v);   check(v == 0, "R9 pin0 vector untouched", v, 32'd0);
        wr(16'h1202, 32'h0012_3456);
        rd(vaddr(0), v);   check(v == 0, "R9 unaligned write ignored", v, 32'd0);

        // R10 latency, edge pin 0
        set_vec(0, 22'h2A5C3);
        @(negedge clk); irq[0] = 1'b1;
        @(negedge clk); check(!msg_valid, "R10 one edge", 32'(msg_valid), 32'd0);
        @(negedge clk); check(msg_valid, "R10 two edges", 32'(msg_valid), 32'd1);
        take_msg("R10 message", 0);
        irq[0] = 1'b0; clear_pin(0);

        // R4 edge behaviour
        set_vec(20, 22'h1F00A);
        irq[20] = 1'b1;
        take_msg("R4 edge message", 20);
        expect_quiet("R4 held high no repeat", 10);
        clear_pin(20);
        expect_quiet("R4 clear while high", 8);
        @(negedge clk); irq[20] = 1'b0;
        @(negedge clk); irq[20] = 1'b1;
        take_msg("R4 new edge", 20);
        irq[20] = 1'b0; clear_pin(20);
        expect_quiet("R4 after final clear", 6);

        // R5 level behaviour, R6 write-0
        set_vec(10, 22'h0ABCD);
        set_mode(10, 1'b1);
        irq[10] = 1'b1;
        take_msg("R5 level message", 10);
        expect_quiet("R5 no repeat before clear", 8);
        wr(caddr(10), 32'h0);
        expect_quiet("R6 write zero no effect", 6);
        clear_pin(10);
        take_msg("R5 retrigger on clear", 10);
        irq[10] = 1'b0; clear_pin(10);
        expect_quiet("R5 clear when low", 6);
        set_mode(10, 1'b0);

        // R8 priority
        set_vec(205, 22'h3CDEF);
        set_vec(5, 22'h01234);
        @(negedge clk); irq[205] = 1'b1; irq[5] = 1'b1;
        take_msg("R8 lowest first", 5);
        take_msg("R8 then higher", 205);
        irq[205] = 1'b0; irq[5] = 1'b0;
        clear_pin(5); clear_pin(205);

        // R1 last pin explicit addresses
        wr(16'h23FC, 32'h0027_7BEE);
        mvec[255] = 22'h277BEE;
        wr(16'h200C, 32'h8000_0000);
        irq[255] = 1'b1;
        take_msg("R1 last pin vector", 255);
        wr(16'hA01C, 32'h8000_0000);
        take_msg("R1 clear bit of last pin", 255);
        irq[255] = 1'b0;
        wr(16'hA01C, 32'h8000_0000);
        expect_quiet("R1 last pin cleared", 6);
        wr(16'h200C, 32'h0);

        // Random rounds
        for (int r = 0; r < 30; r++) begin
            logic [NPINS-1:0] sel;
            bit lvl;
            int k;
            sel = '0;
            lvl = 1'($urandom % 2);
            k = 1 + int'($urandom % 5);
            for (int j = 0; j < k; j++) begin
                int i;
                i = int'($urandom % NPINS);
                if (!sel[i]) begin
                    sel[i] = 1'b1;
                    set_vec(i, 22'($urandom));
                    if (lvl) set_mode(i, 1'b1);
                end
            end
            @(negedge clk); irq = sel;
            for (int i = 0; i < NPINS; i++)
                if (sel[i]) take_msg(lvl ? "R5 R8 random order" : "R4 R8 random order", i);
            expect_quiet("R4 R5 no extra message", 5);
            irq = '0;
            for (int i = 0; i < NPINS; i++) begin
                if (sel[i]) begin
                    clear_pin(i);
                    if (lvl) set_mode(i, 1'b0);
                end
            end
            expect_quiet("R6 random clear quiet", 4);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule